// File: doc/BRIEF.md
# Dual-Mode Host Microprocessor Port

This block is a slave-side parallel port. An external processor uses it to read and write the registers inside the chip. Everything runs on the bus clock supplied by the host, and every host pin is sampled on the rising edge of that clock.

A static style input chooses the handshake style:

- **Split style** (`style_sel = 0`): separate active-low read and write strobes, plus a ready line. Ready is pulled low while the access is in progress.
- **Combined style** (`style_sel = 1`): one read/write direction line, an active-low data strobe, and an acknowledge line. Acknowledge is pulled low once the access has finished.

The two styles share the pins `wr_rw`, `rd_ds` and the handshake pin. Ready and acknowledge are open-drain signals. The block models each of them as a single pull-low enable, `hs_oe`; the resolved pin level is the inverse of `hs_oe`.

Inside the chip, the port drives a register-file bus with a request and an acknowledge. The bus may take any number of cycles to answer. Each access carries an 8-bit direct address and a 16-bit data word. The `wide_mode` input is the data-width bit of the I/O access control register. When it is low, only the low byte lane is used. A high level on `serial_sel` hands the pins to the alternate serial port, and this port then stays silent.

The state machine has four states:

- **IDLE**: waits for a valid start.
- **ISSUE**: the internal request is outstanding.
- **HOLD**: the access is done and its result is presented to the host.
- **REARM**: split style only; waits for chip select to be released.

Its transitions are:

- **IDLE→ISSUE** (launch): a valid start is sampled while `serial_sel` is low.
- **ISSUE→HOLD** (capture): the internal acknowledge arrives.
- **HOLD→IDLE**: combined style, once chip select or the data strobe is seen high.
- **HOLD→REARM**: split style, once chip select or the active strobe is seen high.
- **REARM→IDLE**: chip select is seen high.

Top module: `hostport_top`

## Requirements
- R1: While `hrst_n` is low, `bus_req`, `hs_oe` and `data_oe` are all 0.
- R2: In split style, an access starts when `cs_n`=0 and exactly one of `wr_rw` (write strobe, active low) or `rd_ds` (read strobe, active low) is 0 at a clock edge. If both strobes are low, nothing starts. Each started access issues exactly one internal request.
- R3: In split style, `hs_oe` is 1 (ready pulled low) from the cycle after the start until the internal acknowledge is taken. It returns to 0 in the cycle after that.
- R4: In combined style, an access starts when `cs_n`=0 and `rd_ds` (data strobe, active low) is 0. The direction comes from `wr_rw`: 1 means read and 0 means write.
- R5: In combined style, `hs_oe` becomes 1 (acknowledge pulled low) in the cycle after the internal acknowledge. It stays 1 until `cs_n` or `rd_ds` is sampled high, and is 0 in the following cycle.
- R6: `bus_req` stays high until `bus_ack`, whatever the latency. While it is high, `bus_addr`, `bus_we` and `bus_wdata` are held stable. `bus_addr` is the address sampled at the start, and `bus_we`=1 marks a write.
- R7: Read data is captured from `bus_rdata` on `bus_ack`. It is driven on `data_out`, with `data_oe` set, only in HOLD of a read, and stops in the cycle after the strobe or chip select is seen high. `data_oe` is never set during a write or while a request is pending.
- R8: With `wide_mode`=1, `bus_wmask`=2'b11 and `data_oe`=2'b11 on reads. With `wide_mode`=0, `bus_wmask`=2'b01, only the low data byte is written, `data_oe[1]`=0, and `data_out[15:8]`=0.
- R9: While `serial_sel` is 1, no access is launched, and `hs_oe` and `data_oe` are 0.
- R10: In split style, no new access starts until `cs_n` has been high. In combined style, a new access starts after either `rd_ds` or `cs_n` has been high, so toggling the data strobe under a held chip select gives one access per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host-supplied bus clock |
| hrst_n | input | 1 | Active-low reset |
| style_sel | input | 1 | Static handshake style: 0 split, 1 combined |
| serial_sel | input | 1 | High when the alternate serial port owns the pins |
| wide_mode | input | 1 | Data width: 1 = 16 bits, 0 = 8 bits |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 8 | Direct register address |
| wr_rw | input | 1 | Split: write strobe (active low); combined: direction (1 = read) |
| rd_ds | input | 1 | Split: read strobe; combined: data strobe; both active low |
| data_in | input | 16 | Host write data |
| data_out | output | 16 | Read data toward the host |
| data_oe | output | 2 | Per-byte drive enable for `data_out` |
| hs_oe | output | 1 | Pull-low enable of the open-drain ready/acknowledge pin |
| bus_req | output | 1 | Internal request |
| bus_we | output | 1 | Internal request is a write |
| bus_addr | output | 8 | Internal address |
| bus_wdata | output | 16 | Internal write data |
| bus_wmask | output | 2 | Byte lanes taking part in the access |
| bus_ack | input | 1 | Internal acknowledge, one-cycle pulse |
| bus_rdata | input | 16 | Internal read data, valid with `bus_ack` |

## Verification
A wrong state shows at the handshake pin within one cycle. In split style, a machine stuck in ISSUE holds ready low indefinitely. In combined style, leaving HOLD early drops the acknowledge while the strobe is still low. A missing REARM shows up as an extra internal request the moment a strobe is reasserted under a held chip select, and a wrong lane register shows as a corrupted upper byte or a driven upper data lane.

// File: rtl/hp_pkg.sv
package hp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2,
        ST_REARM = 2'd3
    } hp_state_e;

    localparam logic STYLE_SPLIT    = 1'b0;
    localparam logic STYLE_COMBINED = 1'b1;
endpackage

// File: rtl/hp_decode.sv
module hp_decode (
    input  logic style_sel,
    input  logic cs_n,
    input  logic wr_rw,
    input  logic rd_ds,
    input  logic cap_read,
    output logic start_ok,
    output logic start_read,
    output logic release_hold,
    output logic rearm_ok
);
    // Pin meaning is chosen by the static style input.
    always_comb begin
        if (style_sel == 1'b0) begin
            // split: exactly one active-low strobe must be asserted
            start_ok     = !cs_n && (rd_ds ^ wr_rw);
            start_read   = !rd_ds;
            release_hold = cs_n || (cap_read ? rd_ds : wr_rw);
            rearm_ok     = cs_n;
        end else begin
            // combined: data strobe qualifies, direction line picks read
            start_ok     = !cs_n && !rd_ds;
            start_read   = wr_rw;
            release_hold = cs_n || rd_ds;
            rearm_ok     = 1'b1;
        end
    end
endmodule

// File: rtl/hp_fsm.sv
module hp_fsm
    import hp_pkg::*;
(
    input  logic hclk,
    input  logic hrst_n,
    input  logic style_sel,
    input  logic serial_sel,
    input  logic start_ok,
    input  logic release_hold,
    input  logic rearm_ok,
    input  logic cap_read,
    input  logic bus_ack,
    output logic launch,
    output logic capture,
    output logic bus_req,
    output logic hs_oe,
    output logic drive_data
);
    hp_state_e state_q;
    hp_state_e state_d;

    always_ff @(posedge hclk or negedge hrst_n) begin
        if (!hrst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok && !serial_sel) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (bus_ack) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (release_hold) begin
                    state_d = (style_sel == STYLE_COMBINED) ? ST_IDLE : ST_REARM;
                end
            end
            ST_REARM: begin
                if (rearm_ok) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        launch     = 1'b0;
        capture    = 1'b0;
        bus_req    = 1'b0;
        hs_oe      = 1'b0;
        drive_data = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                launch = start_ok && !serial_sel;
            end
            ST_ISSUE: begin
                bus_req = 1'b1;
                capture = bus_ack;
                hs_oe   = (style_sel == STYLE_SPLIT) && !serial_sel;
            end
            ST_HOLD: begin
                hs_oe      = (style_sel == STYLE_COMBINED) && !serial_sel;
                drive_data = cap_read && !serial_sel;
            end
            ST_REARM: begin
                hs_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hp_lanes.sv
module hp_lanes #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              hclk,
    input  logic              hrst_n,
    input  logic              launch,
    input  logic              start_read,
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              drive_data,
    output logic              cap_read,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W/8-1:0] bus_wmask,
    output logic [DATA_W-1:0] data_out,
    output logic [DATA_W/8-1:0] data_oe
);
    localparam int LANES = DATA_W / 8;

    logic [ADDR_W-1:0] addr_q;
    logic              read_q;
    logic [LANES-1:0]  lane_q;

    always_ff @(posedge hclk or negedge hrst_n) begin
        if (!hrst_n) begin
            addr_q <= '0;
            read_q <= 1'b0;
        end else if (launch) begin
            addr_q <= addr;
            read_q <= start_read;
        end
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic       lane_on;
            logic [7:0] wbyte_q;
            logic [7:0] rbyte_q;

            // lane 0 always takes part; upper lanes only in wide mode
            assign lane_on = (g == 0) || wide_mode;

            always_ff @(posedge hclk or negedge hrst_n) begin
                if (!hrst_n) begin
                    lane_q[g] <= 1'b0;
                    wbyte_q   <= '0;
                end else if (launch) begin
                    lane_q[g] <= lane_on;
                    wbyte_q   <= lane_on ? data_in[g*8 +: 8] : 8'h00;
                end
            end

            always_ff @(posedge hclk or negedge hrst_n) begin
                if (!hrst_n) begin
                    rbyte_q <= '0;
                end else if (capture) begin
                    rbyte_q <= lane_q[g] ? bus_rdata[g*8 +: 8] : 8'h00;
                end
            end

            assign bus_wdata[g*8 +: 8] = wbyte_q;
            assign data_oe[g]          = drive_data && lane_q[g];
            assign data_out[g*8 +: 8]  = (drive_data && lane_q[g]) ? rbyte_q : 8'h00;
        end
    endgenerate

    assign cap_read  = read_q;
    assign bus_addr  = addr_q;
    assign bus_we    = !read_q;
    assign bus_wmask = lane_q;
endmodule

// File: rtl/hostport_top.sv
module hostport_top #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                hclk,
    input  logic                hrst_n,
    input  logic                style_sel,
    input  logic                serial_sel,
    input  logic                wide_mode,
    input  logic                cs_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_rw,
    input  logic                rd_ds,
    input  logic [DATA_W-1:0]   data_in,
    output logic [DATA_W-1:0]   data_out,
    output logic [DATA_W/8-1:0] data_oe,
    output logic                hs_oe,
    output logic                bus_req,
    output logic                bus_we,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W/8-1:0] bus_wmask,
    input  logic                bus_ack,
    input  logic [DATA_W-1:0]   bus_rdata
);
    logic start_ok;
    logic start_read;
    logic release_hold;
    logic rearm_ok;
    logic cap_read;
    logic launch;
    logic capture;
    logic drive_data;

    hp_decode u_decode (
        .style_sel    (style_sel),
        .cs_n         (cs_n),
        .wr_rw        (wr_rw),
        .rd_ds        (rd_ds),
        .cap_read     (cap_read),
        .start_ok     (start_ok),
        .start_read   (start_read),
        .release_hold (release_hold),
        .rearm_ok     (rearm_ok)
    );

    hp_fsm u_fsm (
        .hclk         (hclk),
        .hrst_n       (hrst_n),
        .style_sel    (style_sel),
        .serial_sel   (serial_sel),
        .start_ok     (start_ok),
        .release_hold (release_hold),
        .rearm_ok     (rearm_ok),
        .cap_read     (cap_read),
        .bus_ack      (bus_ack),
        .launch       (launch),
        .capture      (capture),
        .bus_req      (bus_req),
        .hs_oe        (hs_oe),
        .drive_data   (drive_data)
    );

    hp_lanes #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lanes (
        .hclk       (hclk),
        .hrst_n     (hrst_n),
        .launch     (launch),
        .start_read (start_read),
        .wide_mode  (wide_mode),
        .addr       (addr),
        .data_in    (data_in),
        .capture    (capture),
        .bus_rdata  (bus_rdata),
        .drive_data (drive_data),
        .cap_read   (cap_read),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_wmask  (bus_wmask),
        .data_out   (data_out),
        .data_oe    (data_oe)
    );
endmodule

// File: rtl/hp_checker.sv
module hp_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic                hclk,
    input logic                hrst_n,
    input logic                style_sel,
    input logic                serial_sel,
    input logic                wide_mode,
    input logic                cs_n,
    input logic                rd_ds,
    input logic [DATA_W/8-1:0] data_oe,
    input logic                hs_oe,
    input logic                bus_req,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W/8-1:0] bus_wmask,
    input logic                bus_ack
);
    // R6: request and its payload stay put until acknowledged
    a_r6_req_held: assert property (@(posedge hclk) disable iff (!hrst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_wdata)));

    // R3: split style keeps ready low while the request is outstanding
    a_r3_ready_low_busy: assert property (@(posedge hclk) disable iff (!hrst_n)
        (!style_sel && bus_req && !serial_sel) |-> hs_oe);

    // R5: combined-style acknowledge is held while both selects stay low
    a_r5_ack_held: assert property (@(posedge hclk) disable iff (!hrst_n)
        (style_sel && hs_oe && !cs_n && !rd_ds && !serial_sel) |=> (hs_oe || serial_sel));

    // R5: combined style never acknowledges while the request is pending
    a_r5_no_early_ack: assert property (@(posedge hclk) disable iff (!hrst_n)
        (style_sel && bus_req) |-> !hs_oe);

    // R8: narrow writes touch only the low lane
    a_r8_narrow_mask: assert property (@(posedge hclk) disable iff (!hrst_n)
        (bus_req && bus_we && !wide_mode) |-> (bus_wmask == 2'b01));

    // R9: serial port owns the pins, nothing is driven
    a_r9_serial_quiet: assert property (@(posedge hclk) disable iff (!hrst_n)
        serial_sel |-> (!hs_oe && data_oe == '0));

    // R9: no request is launched while the serial port is selected
    a_r9_no_launch: assert property (@(posedge hclk) disable iff (!hrst_n)
        $rose(bus_req) |-> !$past(serial_sel));

    // R7: data bus is not driven while an access is in flight
    a_r7_no_drive_busy: assert property (@(posedge hclk) disable iff (!hrst_n)
        bus_req |-> (data_oe == '0));
endmodule

bind hostport_top hp_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .hclk       (hclk),
    .hrst_n     (hrst_n),
    .style_sel  (style_sel),
    .serial_sel (serial_sel),
    .wide_mode  (wide_mode),
    .cs_n       (cs_n),
    .rd_ds      (rd_ds),
    .data_oe    (data_oe),
    .hs_oe      (hs_oe),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wmask  (bus_wmask),
    .bus_ack    (bus_ack)
);

// File: tb/sim_hostport_top.sv
`timescale 1ns/1ps
module sim_hostport_top;
    logic        hclk = 1'b0;
    logic        hrst_n = 1'b0;
    logic        style_sel = 1'b0;
    logic        serial_sel = 1'b0;
    logic        wide_mode = 1'b1;
    logic        cs_n = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_rw = 1'b1;
    logic        rd_ds = 1'b1;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic [1:0]  data_oe;
    logic        hs_oe;
    logic        bus_req;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [1:0]  bus_wmask;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;

    int checks = 0;
    int failures = 0;
    int req_rises = 0;
    int lat_cfg = 0;
    logic [15:0] mem [256];

    always #2.5 hclk = ~hclk;

    hostport_top u0 (
        .hclk(hclk), .hrst_n(hrst_n), .style_sel(style_sel), .serial_sel(serial_sel),
        .wide_mode(wide_mode), .cs_n(cs_n), .addr(addr), .wr_rw(wr_rw), .rd_ds(rd_ds),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .hs_oe(hs_oe),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wmask(bus_wmask), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // register-file model with programmable latency
    initial begin
        int cnt;
        logic prev;
        cnt = 0;
        prev = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5A00;
        forever begin
            @(negedge hclk);
            if (bus_req && !prev) req_rises++;
            prev = bus_req;
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (cnt >= lat_cfg) begin
                    bus_rdata = mem[bus_addr];
                    if (bus_we) begin
                        if (bus_wmask[0]) mem[bus_addr][7:0]  = bus_wdata[7:0];
                        if (bus_wmask[1]) mem[bus_addr][15:8] = bus_wdata[15:8];
                    end
                    bus_ack = 1'b1;
                    cnt = 0;
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge hclk);
    endtask

    task automatic wait_oe(input logic level);
        for (int i = 0; i < 40 && hs_oe != level; i++) @(negedge hclk);
    endtask

    task automatic t_reset;
        chk(!bus_req && !hs_oe && data_oe == 2'b00, "R1 quiet in reset",
            {bus_req, hs_oe, data_oe}, 0);
    endtask

    task automatic t_split_write(input logic [7:0] a, input logic [15:0] d, input int lat);
        int n0;
        logic [15:0] exp;
        lat_cfg = lat;
        @(negedge hclk);
        n0 = req_rises;
        exp = wide_mode ? d : {mem[a][15:8], d[7:0]};
        addr = a; data_in = d; wr_rw = 1'b0; cs_n = 1'b0;
        @(negedge hclk);
        chk(hs_oe == 1'b1, "R3 ready pulled low after start", hs_oe, 1);
        chk(bus_we == 1'b1 && bus_addr == a, "R6 write request payload", {bus_we, bus_addr}, {1'b1, a});
        if (!wide_mode)
            chk(bus_wmask == 2'b01, "R8 narrow write mask", bus_wmask, 2'b01);
        wait_oe(1'b0);
        chk(hs_oe == 1'b0, "R3 ready released after completion", hs_oe, 0);
        wr_rw = 1'b1; cs_n = 1'b1;
        idle(2);
        chk(req_rises == n0 + 1, "R2 one request per split access", req_rises, n0 + 1);
        chk(mem[a] == exp, "R8 split write data", mem[a], exp);
    endtask

    task automatic t_split_read(input logic [7:0] a, input int lat);
        int n0;
        logic [15:0] exp;
        lat_cfg = lat;
        @(negedge hclk);
        n0 = req_rises;
        exp = wide_mode ? mem[a] : {8'h00, mem[a][7:0]};
        addr = a; rd_ds = 1'b0; cs_n = 1'b0;
        @(negedge hclk);
        chk(hs_oe == 1'b1 && data_oe == 2'b00, "R7 no drive while busy", {hs_oe, data_oe}, 3'b100);
        wait_oe(1'b0);
        chk(data_out == exp, "R7 read data", data_out, exp);
        chk(data_oe == (wide_mode ? 2'b11 : 2'b01), "R8 read lane enables", data_oe,
            wide_mode ? 2'b11 : 2'b01);
        rd_ds = 1'b1;
        @(negedge hclk);
        chk(data_oe == 2'b00, "R7 drive stops after strobe release", data_oe, 0);
        rd_ds = 1'b0;
        idle(6);
        chk(req_rises == n0 + 1, "R10 split needs chip select release", req_rises, n0 + 1);
        rd_ds = 1'b1; cs_n = 1'b1;
        idle(2);
    endtask

    task automatic t_comb_access(input logic rd, input logic [7:0] a, input logic [15:0] d,
                                 input int lat);
        logic [15:0] exp;
        lat_cfg = lat;
        @(negedge hclk);
        exp = rd ? mem[a] : d;
        addr = a; data_in = d; wr_rw = rd; rd_ds = 1'b0; cs_n = 1'b0;
        @(negedge hclk);
        chk(hs_oe == 1'b0, "R5 no acknowledge while busy", hs_oe, 0);
        wait_oe(1'b1);
        chk(hs_oe == 1'b1, "R5 acknowledge asserted", hs_oe, 1);
        if (rd) chk(data_out == exp && data_oe == 2'b11, "R4 combined read", data_out, exp);
        else    chk(data_oe == 2'b00, "R7 no drive on write", data_oe, 0);
        idle(3);
        chk(hs_oe == 1'b1, "R5 acknowledge held", hs_oe, 1);
        rd_ds = 1'b1;
        @(negedge hclk);
        chk(hs_oe == 1'b0, "R5 acknowledge released", hs_oe, 0);
        cs_n = 1'b1; wr_rw = 1'b1;
        idle(2);
        if (!rd) chk(mem[a] == exp, "R4 combined write", mem[a], exp);
    endtask

    task automatic t_comb_toggle;
        int n0;
        lat_cfg = 1;
        @(negedge hclk);
        n0 = req_rises;
        addr = 8'h21; wr_rw = 1'b1; cs_n = 1'b0;
        for (int k = 0; k < 2; k++) begin
            rd_ds = 1'b0;
            @(negedge hclk);
            wait_oe(1'b1);
            rd_ds = 1'b1;
            idle(2);
        end
        cs_n = 1'b1;
        idle(2);
        chk(req_rises == n0 + 2, "R10 one access per data strobe", req_rises, n0 + 2);
    endtask

    task automatic t_both_strobes;
        int n0;
        @(negedge hclk);
        n0 = req_rises;
        cs_n = 1'b0; wr_rw = 1'b0; rd_ds = 1'b0;
        idle(6);
        chk(req_rises == n0 && !hs_oe, "R2 both strobes low ignored", req_rises, n0);
        cs_n = 1'b1; wr_rw = 1'b1; rd_ds = 1'b1;
        idle(2);
    endtask

    task automatic t_serial;
        int n0;
        @(negedge hclk);
        n0 = req_rises;
        serial_sel = 1'b1;
        cs_n = 1'b0; rd_ds = 1'b0;
        idle(6);
        chk(req_rises == n0, "R9 no launch under serial select", req_rises, n0);
        chk(!hs_oe && data_oe == 2'b00, "R9 pins released", {hs_oe, data_oe}, 0);
        cs_n = 1'b1; rd_ds = 1'b1;
        idle(1);
        serial_sel = 1'b0;
        idle(2);
    endtask

    initial begin
        idle(3);
        t_reset();
        hrst_n = 1'b1;
        idle(2);
        t_split_write(8'h10, 16'hBEEF, 0);
        t_split_write(8'h11, 16'h1357, 5);
        t_split_read(8'h10, 2);
        t_split_read(8'h40, 0);
        t_both_strobes();
        wide_mode = 1'b0;
        t_split_write(8'h12, 16'hABCD, 3);
        t_split_read(8'h12, 1);
        wide_mode = 1'b1;
        t_serial();
        style_sel = 1'b1;
        idle(2);
        t_comb_access(1'b0, 8'h30, 16'hC0DE, 4);
        t_comb_access(1'b1, 8'h30, 16'h0000, 0);
        t_comb_access(1'b1, 8'h77, 16'h0000, 7);
        t_comb_toggle();
        t_serial();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule